// File: doc/BRIEF.md
# Reversible-Gate Eight-Function ALU

This block is a combinational arithmetic-logic unit of parameterised width. Every bit of it is built from three reversible primitives. A two-line controlled-NOT gate copies signals and inverts them. A three-line controlled-swap gate serves as a 2:1 multiplexer. A four-line adder gate, with its fourth line held at zero, produces the sum and the carry of one bit.

A 3-bit operation code chooses one of eight functions. The top code bit separates the logic group from the arithmetic group. The bit slices are chained through their carries, so the result settles after a ripple through every slice. Unused outputs of the primitives are kept as garbage lines and are not read.

A caller drives two operands and the operation code and reads a result word and a carry-out. The block has no clock and no state.

Top module: `rev_alu`

## Requirements
- R1: Code `op_sel` = 3'b000 gives `result` = `opnd_a` XOR `opnd_b`.
- R2: Code 3'b001 gives `result` = NOT(`opnd_a` XOR `opnd_b`).
- R3: Code 3'b010 gives `result` = `opnd_a` AND `opnd_b`.
- R4: Code 3'b011 gives `result` = `opnd_a` OR `opnd_b`.
- R5: For every code with `op_sel[2]` = 0, `carry_out` is 0.
- R6: Code 3'b100 (increment) gives {`carry_out`,`result`} = `opnd_a` + 1. An all-ones operand therefore wraps to 0 with `carry_out` = 1, and `opnd_b` has no effect.
- R7: Code 3'b101 (decrement) gives `result` = `opnd_a` - 1 modulo 2^WIDTH. `carry_out` is 1 exactly when `opnd_a` is not 0, so a zero operand wraps to all-ones with `carry_out` = 0. `opnd_b` has no effect.
- R8: Code 3'b110 (add) gives {`carry_out`,`result`} = `opnd_a` + `opnd_b`. With all-ones plus one, the carry runs from bit 0 to `carry_out`.
- R9: Code 3'b111 (subtract) gives `result` = `opnd_a` - `opnd_b` modulo 2^WIDTH. `carry_out` is 1 exactly when `opnd_a` >= `opnd_b` (no borrow).
- R10: `carry_in` has no effect on `result` or `carry_out` for any code, because each code fixes its own initial carry.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opnd_a | input | WIDTH | First operand |
| opnd_b | input | WIDTH | Second operand |
| op_sel | input | 3 | Operation code; bit 2 = arithmetic group |
| carry_in | input | 1 | External carry, ignored |
| result | output | WIDTH | Result word |
| carry_out | output | 1 | Carry from the top slice; 0 for logic codes |

## Verification
The block holds no state. A wrong internal selection therefore shows up at the ports in the same evaluation as the inputs that expose it, and disappears when those inputs change. A mis-wired operand multiplexer corrupts only the codes that route through it. A wrong initial carry shifts every increment or subtract result by one. A broken ripple link appears only when a carry must cross that slice, which the all-ones and zero boundary operands force.

// File: rtl/rev_alu_pkg.sv
package rev_alu_pkg;
   typedef enum logic [2:0] {
      OP_XOR  = 3'b000,
      OP_XNOR = 3'b001,
      OP_AND  = 3'b010,
      OP_OR   = 3'b011,
      OP_INC  = 3'b100,
      OP_DEC  = 3'b101,
      OP_ADD  = 3'b110,
      OP_SUB  = 3'b111
   } alu_op_e;
endpackage

// File: rtl/rg_cnot.sv
// Two-line reversible controlled-NOT: p passes a, q = a ^ b.
module rg_cnot (
   input  logic a,
   input  logic b,
   output logic p,
   output logic q
);
   assign p = a;
   assign q = a ^ b;
endmodule

// File: rtl/rg_cswap.sv
// Three-line controlled swap: c passes through; when c is high, x and y trade lines.
module rg_cswap (
   input  logic c,
   input  logic x,
   input  logic y,
   output logic p,
   output logic q,
   output logic r
);
   assign p = c;
   assign q = c ? y : x;
   assign r = c ? x : y;
endmodule

// File: rtl/rg_addgate.sv
// Four-line reversible adder gate; with d = 0, r is the sum and s the carry.
module rg_addgate (
   input  logic a,
   input  logic b,
   input  logic c,
   input  logic d,
   output logic p,
   output logic q,
   output logic r,
   output logic s
);
   logic ab_x;
   assign ab_x = a ^ b;
   assign p = a;
   assign q = b;
   assign r = ab_x ^ c;
   assign s = (ab_x & c) ^ (a & b) ^ d;
endmodule

// File: rtl/rg_mux2.sv
// 2:1 select built on a controlled swap: y = sel ? in1 : in0.
module rg_mux2 (
   input  logic sel,
   input  logic in0,
   input  logic in1,
   output logic y
);
   logic sel_unused, other_unused;
   rg_cswap u_sw (
      .c(sel), .x(in0), .y(in1),
      .p(sel_unused), .q(y), .r(other_unused)
   );
endmodule

// File: rtl/rg_fanout.sv
// Chain of controlled-NOT gates with b tied low; each stage adds one copy of x.
module rg_fanout #(
   parameter int COPIES = 4
) (
   input  logic              x,
   output logic [COPIES-1:0] y
);
   if (COPIES < 2) begin : g_copies_bad
      $error("rg_fanout: COPIES must be at least 2");
   end

   logic [COPIES-1:0] link;
   assign link[0] = x;

   for (genvar i = 0; i < COPIES - 1; i++) begin : g_stage
      rg_cnot u_cp (
         .a(link[i]), .b(1'b0), .p(y[i]), .q(link[i+1])
      );
   end
   assign y[COPIES-1] = link[COPIES-1];
endmodule

// File: rtl/rev_alu_slice.sv
// One bit of the ALU: logic functions, operand shaping and the adder gate.
module rev_alu_slice (
   input  logic       a,
   input  logic       b,
   input  logic       cin,
   input  logic [2:0] op,
   output logic       res,
   output logic       cout
);
   localparam int NCOPY = 4;

   logic [NCOPY-1:0] a_cp, b_cp;
   logic [6:0]       gb_unused;
   logic xor_v, xor_cp, xnor_v, and_v, or_v, b_pass, b_inv;
   logic lg_lo, lg_hi, lg_res, k_val, b_alt, b_sel, sum_v;

   rg_fanout #(.COPIES(NCOPY)) u_fan_a (.x(a), .y(a_cp));
   rg_fanout #(.COPIES(NCOPY)) u_fan_b (.x(b), .y(b_cp));

   // logic group
   rg_cnot u_xor  (.a(a_cp[0]), .b(b_cp[0]), .p(gb_unused[0]), .q(xor_v));
   rg_cnot u_xnor (.a(xor_v), .b(1'b1), .p(xor_cp), .q(xnor_v));
   rg_cswap u_and (.c(a_cp[1]), .x(1'b0), .y(b_cp[1]),
                   .p(gb_unused[1]), .q(and_v), .r(gb_unused[2]));
   rg_cswap u_or  (.c(a_cp[2]), .x(b_cp[2]), .y(1'b1),
                   .p(gb_unused[3]), .q(or_v), .r(gb_unused[4]));

   rg_mux2 u_m_lo  (.sel(op[0]), .in0(xor_cp), .in1(xnor_v), .y(lg_lo));
   rg_mux2 u_m_hi  (.sel(op[0]), .in0(and_v),  .in1(or_v),   .y(lg_hi));
   rg_mux2 u_m_log (.sel(op[1]), .in0(lg_lo),  .in1(lg_hi),  .y(lg_res));

   // arithmetic operand: inc 0, dec 1, add b, sub ~b
   rg_cnot u_binv (.a(b_cp[3]), .b(1'b1), .p(b_pass), .q(b_inv));
   rg_mux2 u_m_k   (.sel(op[0]), .in0(1'b0),   .in1(1'b1),  .y(k_val));
   rg_mux2 u_m_b   (.sel(op[0]), .in0(b_pass), .in1(b_inv), .y(b_alt));
   rg_mux2 u_m_bs  (.sel(op[1]), .in0(k_val),  .in1(b_alt), .y(b_sel));

   rg_addgate u_add (
      .a(a_cp[3]), .b(b_sel), .c(cin), .d(1'b0),
      .p(gb_unused[5]), .q(gb_unused[6]), .r(sum_v), .s(cout)
   );

   rg_mux2 u_m_out (.sel(op[2]), .in0(lg_res), .in1(sum_v), .y(res));
endmodule

// File: rtl/rev_alu.sv
module rev_alu
   import rev_alu_pkg::*;
#(
   parameter int WIDTH = 8
) (
   input  logic [WIDTH-1:0] opnd_a,
   input  logic [WIDTH-1:0] opnd_b,
   input  logic [2:0]       op_sel,
   input  logic             carry_in,
   output logic [WIDTH-1:0] result,
   output logic             carry_out
);
   localparam int EXTW = WIDTH + 1;

   if (WIDTH < 1) begin : g_width_bad
      $error("rev_alu: WIDTH must be at least 1");
   end

   logic          cin_unused;
   logic [1:0]    cg_unused;
   logic          op_diff, op_same, carry0;
   logic [WIDTH:0] chain;

   assign cin_unused = carry_in;

   // initial carry: 1 for increment and subtract, 0 otherwise
   rg_cnot u_c_diff (.a(op_sel[0]), .b(op_sel[1]), .p(cg_unused[0]), .q(op_diff));
   rg_cnot u_c_same (.a(op_diff),   .b(1'b1),      .p(cg_unused[1]), .q(op_same));
   rg_mux2 u_c_gate (.sel(op_sel[2]), .in0(1'b0), .in1(op_same), .y(carry0));

   assign chain[0] = carry0;

   for (genvar i = 0; i < WIDTH; i++) begin : g_bit
      rev_alu_slice u_slice (
         .a(opnd_a[i]), .b(opnd_b[i]), .cin(chain[i]), .op(op_sel),
         .res(result[i]), .cout(chain[i+1])
      );
   end

   rg_mux2 u_co_gate (.sel(op_sel[2]), .in0(1'b0), .in1(chain[WIDTH]), .y(carry_out));

   // checks against the arithmetic meaning of each code
   logic [EXTW-1:0] ext_a, ext_b, got;
   assign ext_a = {1'b0, opnd_a};
   assign ext_b = {1'b0, opnd_b};
   assign got   = {carry_out, result};

   always_comb begin
      if (!$isunknown({opnd_a, opnd_b, op_sel})) begin
         // R1
         xor_res_chk: assert (op_sel != OP_XOR || result == (opnd_a ^ opnd_b))
            else $error("xor result mismatch");
         // R5
         logic_cout_chk: assert (op_sel[2] || !carry_out)
            else $error("carry set on logic code");
         // R6
         inc_res_chk: assert (op_sel != OP_INC || got == ext_a + EXTW'(1))
            else $error("increment mismatch");
         // R8
         add_res_chk: assert (op_sel != OP_ADD || got == ext_a + ext_b)
            else $error("add mismatch");
         // R9
         sub_res_chk: assert (op_sel != OP_SUB ||
                              (result == opnd_a - opnd_b && carry_out == (opnd_a >= opnd_b)))
            else $error("subtract mismatch");
      end
   end
endmodule

// File: tb/rev_alu_tb.sv
module rev_alu_tb;
   localparam int N = 8;
   localparam logic [N-1:0] ONES = {N{1'b1}};

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #2 clk = ~clk;

   logic [N-1:0] a = '0, b = '0;
   logic [2:0]   sel = 3'b000;
   logic         cin = 1'b0;
   logic [N-1:0] res;
   logic         co;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 1'b0;

   rev_alu #(.WIDTH(N)) u_dut (
      .opnd_a(a), .opnd_b(b), .op_sel(sel), .carry_in(cin),
      .result(res), .carry_out(co)
   );

   function automatic logic [N:0] model(input logic [2:0] s,
                                        input logic [N-1:0] x, input logic [N-1:0] y);
      logic [N:0] ex, ey;
      ex = {1'b0, x};
      ey = {1'b0, y};
      case (s)
         3'b000: return {1'b0, x ^ y};
         3'b001: return {1'b0, ~(x ^ y)};
         3'b010: return {1'b0, x & y};
         3'b011: return {1'b0, x | y};
         3'b100: return ex + 1;
         3'b101: return ex + {1'b0, ONES};
         3'b110: return ex + ey;
         default: return ex + {1'b0, ~y} + 1;
      endcase
   endfunction

   task automatic drive(input logic [2:0] s, input logic [N-1:0] x,
                        input logic [N-1:0] y, input logic c);
      @(negedge clk);
      sel = s; a = x; b = y; cin = c;
      @(posedge clk);
      #1;
   endtask

   task automatic check(input string req, input logic [N:0] exp);
      n_chk++;
      if ({co, res} !== exp) begin
         n_bad++;
         $display("FAIL %s sel=%b a=%h b=%h got=%h exp=%h", req, sel, a, b, {co, res}, exp);
      end
   endtask

   task automatic run(input string req, input logic [2:0] s,
                      input logic [N-1:0] x, input logic [N-1:0] y);
      drive(s, x, y, 1'b0);
      check(req, model(s, x, y));
   endtask

   task automatic test_reset_state;
      @(posedge clk); #1;
      check("R1 reset", '0);
   endtask

   task automatic test_logic;
      logic [N-1:0] pa [4] = '{8'h00, ONES, 8'hA5, 8'h3C};
      logic [N-1:0] pb [4] = '{ONES, ONES, 8'h5A, 8'h0F};
      for (int i = 0; i < 4; i++) begin
         run("R1", 3'b000, pa[i], pb[i]);
         run("R2", 3'b001, pa[i], pb[i]);
         run("R3", 3'b010, pa[i], pb[i]);
         run("R4", 3'b011, pa[i], pb[i]);
         check("R5", {1'b0, res}); // carry_out must be 0 here
      end
   endtask

   task automatic test_inc;
      run("R6 zero", 3'b100, 8'h00, 8'hFF);
      run("R6 mid",  3'b100, 8'h7F, 8'h12);
      drive(3'b100, ONES, 8'h55, 1'b0);
      check("R6 wrap", {1'b1, {N{1'b0}}});
   endtask

   task automatic test_dec;
      drive(3'b101, 8'h00, 8'hAA, 1'b0);
      check("R7 wrap", {1'b0, ONES});
      run("R7 one",  3'b101, 8'h01, 8'h00);
      run("R7 ones", 3'b101, ONES, ONES);
   endtask

   task automatic test_add;
      drive(3'b110, ONES, 8'h01, 1'b0);
      check("R8 ripple", {1'b1, {N{1'b0}}});
      run("R8 zero", 3'b110, 8'h00, 8'h00);
      run("R8 max",  3'b110, ONES, ONES);
   endtask

   task automatic test_sub;
      run("R9 eq",     3'b111, 8'h42, 8'h42);
      drive(3'b111, 8'h00, 8'h01, 1'b0);
      check("R9 borrow", {1'b0, ONES});
      run("R9 big",    3'b111, ONES, 8'h00);
   endtask

   task automatic test_cin_ignored;
      for (int s = 0; s < 8; s++) begin
         drive(3'(s), 8'h96, 8'h69, 1'b1);
         check("R10", model(3'(s), 8'h96, 8'h69));
      end
      drive(3'b100, ONES, 8'h00, 1'b1);
      check("R10 inc", {1'b1, {N{1'b0}}});
   endtask

   task automatic test_random;
      string tags [8] = '{"R1", "R2", "R3", "R4", "R6", "R7", "R8", "R9"};
      for (int k = 0; k < 200; k++) begin
         logic [N-1:0] x, y;
         x = N'($urandom);
         y = N'($urandom);
         run(tags[k % 8], 3'(k % 8), x, y);
      end
   endtask

   initial begin
      #(4 * 200000);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog expired");
         $display("test done: total=%0d bad=%0d", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      rst_n = 1'b1;
      test_reset_state();
      test_logic();
      test_inc();
      test_dec();
      test_add();
      test_sub();
      test_cin_ignored();
      test_random();
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end
endmodule